// File: doc/BRIEF.md
# Maskable interrupt request controller

This block gathers single-bit event pulses from several status sources into a small set of latched interrupt registers and drives one active-low request line towards a host processor. Each latched bit has a mask bit beside it; a masked source still records its event, so a host that polls can see it, but it never pulls the request line down. The host learns which sources fired by reading the interrupt registers, and each read clears the register it targets.

The block follows the serial-bus read traffic through three plain strobes (read start with its register address, read stop, and one pulse per bus clock). When a read starts on the last register that still holds an active unmasked bit, the line goes high in the same cycle the register clears. Any unmasked event captured while a read sequence is open holds the line high for a fixed number of bus clocks. An event that arrives while that wait is running starts it again. When the wait runs out, the line falls if an unmasked bit is still pending. One status bit records an undervoltage condition and survives only while a supply-present input stays high.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every interrupt bit is 0, every mask bit is 1 (masked) and `irq_n` is 1.
- R2: Bit j of register i (i = 0..NREG-1, j = 0..RW-1) latches on a rising edge of `evt[i*RW+j]`. An input that stays high latches once and does not set the bit again after a read.
- R3: With no wait running, an unmasked event makes `irq_n` low one clock after the cycle in which the event input rises.
- R4: A masked event (mask bit 1) sets its interrupt bit but leaves `irq_n` high.
- R5: A cycle with `rd_start` high and `rd_addr` = i returns register i on `rd_data`, with `rd_valid` high, one clock later, and clears register i. An event that rises in that same cycle stays latched.
- R6: `irq_n` goes high on the clock after the read of the last register with an unmasked pending bit begins. It stays low while any other register still holds an unmasked pending bit.
- R7: An unmasked event captured while a read sequence is open (from the `rd_start` cycle up to `rd_stop`), or while a wait is already running, starts a wait of DLY pulses of `scl_tick`, restarting any running wait. During the wait, `irq_n` stays high if it was high.
- R8: On the clock that brings the DLY-th `scl_tick` pulse of the wait, `irq_n` goes low if an unmasked bit is pending.
- R9: Bit 0 of register 0 (undervoltage) is cleared on every clock in which `supply_ok` is low.
- R10: A read with `rd_addr` >= NREG returns 0 with `rd_valid` high and changes no interrupt bit.
- R11: A cycle with `mask_we` high loads `mask_wdata` into the mask of register `mask_addr`. Clearing the mask of a pending bit with no wait running pulls `irq_n` low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | NREG*RW | Event inputs, latched on rising edge |
| supply_ok | input | 1 | Supply-present qualifier for the undervoltage bit |
| mask_we | input | 1 | Mask write strobe |
| mask_addr | input | AW | Register index of the mask write |
| mask_wdata | input | RW | New mask value, 1 = masked |
| rd_start | input | 1 | A bus read of an interrupt register starts |
| rd_addr | input | AW | Register index of the read |
| rd_stop | input | 1 | The bus read sequence ends |
| scl_tick | input | 1 | One pulse per bus clock cycle |
| rd_valid | output | 1 | `rd_data` holds the register just read |
| rd_data | output | RW | Read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest state to reach is a wait that restarts. The line must have been released by a read, an unmasked event must land inside the open read, and a second event must arrive partway through the bus-clock count. The stimulus builds this state in order: it latches a bit, reads that register to release the line, raises events at chosen points while the read is open, and then counts `scl_tick` pulses one at a time. The line is checked just before and just after the exact pulse on which it should fall.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned IRQ_WAIT_DEF = 24;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_OPEN = 1'b1
  } rd_phase_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned RW       = 8,
  parameter bit          HAS_UVLO = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] evt,
  input  logic          supply_ok,
  input  logic          rd_sel,
  input  logic          mask_sel,
  input  logic [RW-1:0] mask_wdata,
  output logic [RW-1:0] stat,
  output logic [RW-1:0] mask,
  output logic          new_unm,
  output logic          pend_nxt,
  output logic          pend_old_nxt
);
  logic [RW-1:0] evt_q, stat_q, mask_q;
  logic [RW-1:0] rise, stat_d, kept_d, mask_d;

  always_comb begin
    rise   = evt & ~evt_q;
    kept_d = rd_sel ? '0 : stat_q;
    mask_d = mask_sel ? mask_wdata : mask_q;
    stat_d = kept_d | rise;
    if (HAS_UVLO && !supply_ok) begin
      stat_d[0] = 1'b0;
      kept_d[0] = 1'b0;
    end
    new_unm      = |(rise & ~mask_d);
    pend_nxt     = |(stat_d & ~mask_d);
    pend_old_nxt = |(kept_d & ~mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      evt_q  <= evt;
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign stat = stat_q;
  assign mask = mask_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned DLY = 24,
  localparam int unsigned CW = $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic new_evt,
  input  logic scl_tick,
  input  logic pend_nxt,
  input  logic pend_old_nxt,
  output logic hold,
  output logic irq_n
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, hold_d;

  always_comb begin
    cnt_d = cnt_q;
    if (new_evt && (busy || cnt_q != '0))
      cnt_d = CW'(DLY);
    else if (scl_tick && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    hold_d = (cnt_d != '0);
    act_d  = (act_q && pend_old_nxt) || (pend_nxt && !hold_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign hold  = (cnt_q != '0);
  assign irq_n = ~act_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned NREG = 3,
  parameter int unsigned RW   = 8,
  parameter int unsigned AW   = 4,
  parameter int unsigned DLY  = irq_pkg::IRQ_WAIT_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG*RW-1:0] evt,
  input  logic               supply_ok,
  input  logic               mask_we,
  input  logic [AW-1:0]      mask_addr,
  input  logic [RW-1:0]      mask_wdata,
  input  logic               rd_start,
  input  logic [AW-1:0]      rd_addr,
  input  logic               rd_stop,
  input  logic               scl_tick,
  output logic               rd_valid,
  output logic [RW-1:0]      rd_data,
  output logic               irq_n
);
  import irq_pkg::*;

  logic [NREG-1:0][RW-1:0] stat_all, mask_all;
  logic [NREG-1:0]         new_v, pend_v, pend_old_v;
  logic [NREG-1:0]         pend_now_v;
  logic                    pend_now, hold, busy;
  rd_phase_e               phase_q;
  logic [RW-1:0]           rd_mux, rd_data_q;
  logic                    rd_valid_q;

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    irq_bank #(.RW(RW), .HAS_UVLO(g == 0)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt[g*RW +: RW]),
      .supply_ok   (supply_ok),
      .rd_sel      (rd_start && rd_addr == AW'(g)),
      .mask_sel    (mask_we && mask_addr == AW'(g)),
      .mask_wdata  (mask_wdata),
      .stat        (stat_all[g]),
      .mask        (mask_all[g]),
      .new_unm     (new_v[g]),
      .pend_nxt    (pend_v[g]),
      .pend_old_nxt(pend_old_v[g])
    );
    assign pend_now_v[g] = |(stat_all[g] & ~mask_all[g]);
  end

  assign pend_now = |pend_now_v;
  assign busy     = rd_start || (phase_q == RD_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= RD_IDLE;
    else if (rd_start) phase_q <= RD_OPEN;
    else if (rd_stop) phase_q <= RD_IDLE;
  end

  irq_gate #(.DLY(DLY)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .new_evt     (|new_v),
    .scl_tick    (scl_tick),
    .pend_nxt    (|pend_v),
    .pend_old_nxt(|pend_old_v),
    .hold        (hold),
    .irq_n       (irq_n)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_mux = stat_all[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_start;
      if (rd_start) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_n,
  input logic supply_ok,
  input logic uvlo_bit,
  input logic pend_now,
  input logic hold,
  input logic rd_start,
  input logic rd_valid
);
  // R4
  low_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> pend_now);

  // R6
  release_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_now |-> irq_n);

  // R7
  wait_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(irq_n)) |-> irq_n);

  // R9
  uvlo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(supply_ok) |-> !uvlo_bit);

  // R5
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> rd_valid);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_n    (irq_n),
  .supply_ok(supply_ok),
  .uvlo_bit (stat_all[0][0]),
  .pend_now (pend_now),
  .hold     (hold),
  .rd_start (rd_start),
  .rd_valid (rd_valid)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  localparam int NREG = 2;
  localparam int RW   = 4;
  localparam int AW   = 4;
  localparam int DLY  = 24;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NREG*RW-1:0] evt = '0;
  logic               supply_ok = 1'b1;
  logic               mask_we = 1'b0;
  logic [AW-1:0]      mask_addr = '0;
  logic [RW-1:0]      mask_wdata = '0;
  logic               rd_start = 1'b0;
  logic [AW-1:0]      rd_addr = '0;
  logic               rd_stop = 1'b0;
  logic               scl_tick = 1'b0;
  logic               rd_valid;
  logic [RW-1:0]      rd_data;
  logic               irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [RW-1:0] got;

  always #10 clk = ~clk;

  irq_ctrl #(.NREG(NREG), .RW(RW), .AW(AW), .DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt), .supply_ok(supply_ok),
    .mask_we(mask_we), .mask_addr(mask_addr), .mask_wdata(mask_wdata),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_stop(rd_stop),
    .scl_tick(scl_tick), .rd_valid(rd_valid), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(int idx);
    evt[idx] = 1'b1; tick(); evt[idx] = 1'b0;
  endtask

  task automatic rd(int a, output logic [RW-1:0] d);
    rd_start = 1'b1; rd_addr = AW'(a); tick(); rd_start = 1'b0;
    chk("R5 valid", rd_valid, 1);
    d = rd_data;
  endtask

  task automatic stop();
    rd_stop = 1'b1; tick(); rd_stop = 1'b0;
  endtask

  task automatic scl();
    scl_tick = 1'b1; tick(); scl_tick = 1'b0;
  endtask

  task automatic wmask(int a, logic [RW-1:0] m);
    mask_we = 1'b1; mask_addr = AW'(a); mask_wdata = m; tick(); mask_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq", irq_n, 1);
    for (int r = 0; r < NREG; r++) begin rd(r, got); chk("R1 stat", got, 0); end
    stop();
    // R1 masks set, R4 masked sweep, R5 read and clear
    for (int b = 0; b < NREG*RW; b++) begin
      pulse(b);
      chk("R4 masked irq", irq_n, 1);
      rd(b / RW, got); chk("R5 data", got, 1 << (b % RW));
      rd(b / RW, got); chk("R5 cleared", got, 0);
      stop();
    end
    // R11 unmask all
    for (int r = 0; r < NREG; r++) wmask(r, '0);
    // R3, R6 sweep
    for (int b = 0; b < NREG*RW; b++) begin
      pulse(b);
      chk("R3 irq low", irq_n, 0);
      rd(b / RW, got); chk("R2 latched", got, 1 << (b % RW));
      chk("R6 released", irq_n, 1);
      stop();
    end
    // R6 two registers pending
    pulse(0); pulse(RW);
    rd(0, got); chk("R6 still low", irq_n, 0);
    rd(1, got); chk("R6 high", irq_n, 1);
    stop();
    // R2 held input latches once
    evt[RW+2] = 1'b1; tick(); tick(); tick();
    rd(1, got); chk("R2 once", got, 4'h4);
    rd(1, got); chk("R2 no relatch", got, 0);
    stop();
    evt[RW+2] = 1'b0; tick();
    chk("R2 irq", irq_n, 1);
    // R5 event in the read cycle survives
    pulse(1);
    rd_start = 1'b1; rd_addr = 0; evt[2] = 1'b1; tick();
    rd_start = 1'b0; evt[2] = 1'b0;
    chk("R5 pre-clear data", rd_data, 4'h2);
    stop();
    for (int k = 0; k < DLY; k++) scl();
    rd(0, got); chk("R5 survivor", got, 4'h4);
    stop();
    // R7, R8 event in open read
    pulse(RW);
    rd(1, got); chk("R6 rel", irq_n, 1);
    pulse(3);
    chk("R7 held", irq_n, 1);
    stop();
    for (int k = 0; k < DLY - 1; k++) scl();
    chk("R7 before expiry", irq_n, 1);
    scl();
    chk("R8 at expiry", irq_n, 0);
    rd(0, got); chk("R8 data", got, 4'h8);
    chk("R6 after", irq_n, 1);
    stop();
    // R7 restart
    rd(0, got);
    pulse(1);
    for (int k = 0; k < 10; k++) scl();
    pulse(RW + 2);
    for (int k = 0; k < DLY - 1; k++) scl();
    chk("R7 restart held", irq_n, 1);
    scl();
    chk("R8 restart expiry", irq_n, 0);
    rd(0, got); chk("R7 r0", got, 4'h2);
    chk("R6 r1 still", irq_n, 0);
    rd(1, got); chk("R7 r1", got, 4'h4);
    chk("R6 done", irq_n, 1);
    stop();
    for (int k = 0; k < DLY; k++) scl();
    // R9 undervoltage bit
    pulse(0);
    chk("R9 set", irq_n, 0);
    supply_ok = 1'b0; tick();
    chk("R9 cleared irq", irq_n, 1);
    supply_ok = 1'b1; tick();
    rd(0, got); chk("R9 bit", got, 0);
    stop();
    // R10 out of range
    pulse(RW + 1);
    rd(5, got); chk("R10 data", got, 0);
    chk("R10 irq", irq_n, 0);
    stop();
    for (int k = 0; k < DLY; k++) scl();
    rd(1, got); chk("R10 intact", got, 4'h2);
    stop();
    for (int k = 0; k < DLY; k++) scl();
    // R11 unmask of pending bit
    wmask(0, 4'hF);
    pulse(2);
    chk("R11 masked", irq_n, 1);
    wmask(0, 4'h0);
    chk("R11 unmask asserts", irq_n, 0);
    rd(0, got); chk("R11 data", got, 4'h4);
    stop();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule